// File: doc/BRIEF.md
# Extended Cartridge Bank Address Mapper

This block sits between a 20-bit CPU memory bus and the cartridge memories. The CPU address is split into a 4-bit segment number (bits 19:16) and an in-segment offset. Segments 0x4 through 0xF share one coarse 1 MiB ROM window. Segments 0x2 and 0x3 each have their own 64 KiB ROM window. Segment 0x1 is a 64 KiB window that maps RAM by default. A control bit can point segment 0x1 at ROM instead, so that the cartridge can program its own flash. Segment 0x0 is never a cartridge access.

Software sets up the windows through byte-wide I/O ports. Each bank register can be written through an older 8-bit port or through a newer wide port pair. Both routes store into the same register, so a value written one way reads back the other way. The translated ROM and RAM addresses and their chip selects are combinational from the CPU address and the stored banks. A register write changes the mapping from the next cycle on.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset every register is zero, and every port in the block's map (0xC0–0xC3, 0xCE, 0xCF, 0xD0–0xD5) reads 0x00.
- R2: The 6-bit linear bank register is written by a write to 0xC0 or to 0xCF. It takes io_wdata[5:0]. Both ports read it back in bits 5:0, and bits 7:6 read as zero.
- R3: The window banks are numbered 0, 1 and 2, for segments 0x1, 0x2 and 0x3. A write to the short port 0xC1, 0xC2 or 0xC3 replaces bits 7:0 of window bank 0, 1 or 2 respectively, and leaves bits 9:8 unchanged. Reading the short port returns bits 7:0.
- R4: Each 10-bit window bank n also has a port pair at 0xD0+2n (low byte, bits 7:0) and 0xD1+2n (high byte). A high-byte write stores io_wdata[1:0] into bits 9:8. A high-byte read returns bits 9:8 in bits 1:0, with bits 7:2 as zero.
- R5: For segments 0x4–0xF, rom_addr = {linear bank, cpu_addr[19:0]}. rom_cs equals cpu_req.
- R6: For segments 0x2 and 0x3, rom_addr = {window bank 1 or 2, cpu_addr[15:0]}. rom_cs equals cpu_req.
- R7: In segment 0x1 with the control bit at 0, ram_cs equals cpu_req and rom_cs is 0. ram_addr is always {window bank 0, cpu_addr[15:0]}. rom_cs and ram_cs are never both 1.
- R8: In segment 0x1 with the control bit at 1, rom_cs equals cpu_req, ram_cs is 0, and rom_addr = {window bank 0, cpu_addr[15:0]}.
- R9: In segment 0x0 both chip selects are 0 and rom_addr is zero. Both chip selects are 0 whenever cpu_req is 0.
- R10: Port 0xCE holds the control bit in bit 0, and its bits 7:1 read as zero. Writes to any port outside the map are ignored, and such ports read 0x00.
- R11: A port write sampled at a clock edge changes the translation outputs and the readback right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| io_addr | input | 8 | I/O port number for writes and reads |
| io_wdata | input | 8 | Write data |
| io_we | input | 1 | Write strobe, sampled on the rising clock edge |
| io_rdata | output | 8 | Readback of the port selected by io_addr (combinational) |
| cpu_req | input | 1 | CPU memory access is active |
| cpu_addr | input | 20 | CPU physical address |
| rom_addr | output | 26 | Translated ROM address |
| ram_addr | output | 26 | Translated RAM address |
| rom_cs | output | 1 | ROM chip select |
| ram_cs | output | 1 | RAM chip select |

## Verification
The address translation and the readback are combinational. An output therefore depends only on the present inputs and on the register state after the most recent rising edge. The bench drives its inputs, lets one rising edge pass, and samples at the following falling edge. It compares every output against a behavioural model that applies each write at that same rising edge. Readback of a port just written is therefore due at the first falling edge after the write, and so is the new mapping (R11). The model ignores writes until two edges after reset release, to match the internal reset synchroniser, and the bench issues no writes in that interval.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam logic [7:0] PORT_LIN_SHORT  = 8'hC0;
  localparam logic [7:0] PORT_WIN_SHORT0 = 8'hC1;
  localparam logic [7:0] PORT_CTRL       = 8'hCE;
  localparam logic [7:0] PORT_LIN_WIDE   = 8'hCF;
  localparam logic [7:0] PORT_WIN_WIDE0  = 8'hD0;
  localparam int         NUM_WIN         = 3;

  typedef enum logic [1:0] {
    MAP_NONE = 2'd0,
    MAP_WIN  = 2'd1,
    MAP_LIN  = 2'd2
  } map_kind_e;
endpackage

// File: rtl/cbm_rst_sync.sv
module cbm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/cbm_bank_regs.sv
module cbm_bank_regs
  import cbm_pkg::*;
#(
  parameter int LIN_W  = 6,
  parameter int BANK_W = 10
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             io_we,
  input  logic [7:0]                       io_addr,
  input  logic [7:0]                       io_wdata,
  output logic [7:0]                       io_rdata,
  output logic [LIN_W-1:0]                 lin_bank,
  output logic [NUM_WIN-1:0][BANK_W-1:0]   win_bank,
  output logic                             rom_in_seg1
);
  localparam int HI_W = BANK_W - 8;

  logic [LIN_W-1:0] lin_q, lin_d;
  logic             lin_en;
  logic             ctl_q, ctl_d;
  logic             ctl_en;
  logic [NUM_WIN-1:0][BANK_W-1:0] bank_q;

  // next state for the linear bank and the control bit
  always_comb begin
    lin_en = io_we && ((io_addr == PORT_LIN_SHORT) || (io_addr == PORT_LIN_WIDE));
    lin_d  = io_wdata[LIN_W-1:0];
    ctl_en = io_we && (io_addr == PORT_CTRL);
    ctl_d  = io_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_q <= '0;
      ctl_q <= 1'b0;
    end else begin
      if (lin_en) lin_q <= lin_d;
      if (ctl_en) ctl_q <= ctl_d;
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    localparam logic [7:0] P_SHORT = 8'(PORT_WIN_SHORT0 + g);
    localparam logic [7:0] P_LO    = 8'(PORT_WIN_WIDE0 + 2 * g);
    localparam logic [7:0] P_HI    = 8'(PORT_WIN_WIDE0 + 2 * g + 1);

    logic            lo_en, hi_en;
    logic [7:0]      lo_d;
    logic [HI_W-1:0] hi_d;

    always_comb begin
      lo_en = io_we && ((io_addr == P_SHORT) || (io_addr == P_LO));
      hi_en = io_we && (io_addr == P_HI);
      lo_d  = io_wdata;
      hi_d  = io_wdata[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
      end else begin
        if (lo_en) bank_q[g][7:0]        <= lo_d;
        if (hi_en) bank_q[g][BANK_W-1:8] <= hi_d;
      end
    end

    // short-port write keeps the upper bits
    p_short_keeps_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(io_we && (io_addr == P_SHORT)) |->
        (bank_q[g] == {$past(bank_q[g][BANK_W-1:8]), $past(io_wdata)}));

    // high-byte write keeps the low byte
    p_high_byte_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(io_we && (io_addr == P_HI)) |->
        (bank_q[g] == {$past(io_wdata[HI_W-1:0]), $past(bank_q[g][7:0])}));
  end

  // readback mux
  always_comb begin
    io_rdata = 8'h00;
    if ((io_addr == PORT_LIN_SHORT) || (io_addr == PORT_LIN_WIDE)) io_rdata = 8'(lin_q);
    if (io_addr == PORT_CTRL) io_rdata = {7'b0, ctl_q};
    for (int i = 0; i < NUM_WIN; i++) begin
      if ((io_addr == 8'(PORT_WIN_SHORT0 + i)) || (io_addr == 8'(PORT_WIN_WIDE0 + 2 * i)))
        io_rdata = bank_q[i][7:0];
      if (io_addr == 8'(PORT_WIN_WIDE0 + 2 * i + 1))
        io_rdata = 8'(bank_q[i][BANK_W-1:8]);
    end
  end

  assign lin_bank    = lin_q;
  assign win_bank    = bank_q;
  assign rom_in_seg1 = ctl_q;

  p_lin_alias_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(io_we && ((io_addr == PORT_LIN_SHORT) || (io_addr == PORT_LIN_WIDE))) |->
      (lin_bank == $past(io_wdata[LIN_W-1:0])));

  p_ctrl_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == PORT_CTRL) |-> (io_rdata[7:1] == 7'b0));
endmodule

// File: rtl/cbm_addr_xlate.sv
module cbm_addr_xlate
  import cbm_pkg::*;
#(
  parameter int LIN_W  = 6,
  parameter int BANK_W = 10,
  parameter int CPU_AW = 20,
  parameter int WIN_AW = 16,
  parameter int ROM_AW = 26,
  parameter int RAM_AW = 26
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cpu_req,
  input  logic [CPU_AW-1:0]              cpu_addr,
  input  logic [LIN_W-1:0]               lin_bank,
  input  logic [NUM_WIN-1:0][BANK_W-1:0] win_bank,
  input  logic                           rom_in_seg1,
  output logic [ROM_AW-1:0]              rom_addr,
  output logic [RAM_AW-1:0]              ram_addr,
  output logic                           rom_cs,
  output logic                           ram_cs
);
  localparam int SEG_W = CPU_AW - WIN_AW;

  logic [SEG_W-1:0] seg;
  map_kind_e        kind;
  logic [BANK_W-1:0] sel_bank;
  logic             seg1_ram;

  always_comb begin
    seg      = cpu_addr[CPU_AW-1:WIN_AW];
    kind     = MAP_LIN;
    sel_bank = win_bank[0];
    seg1_ram = 1'b0;
    if (seg == '0) begin
      kind = MAP_NONE;
    end else if (seg <= SEG_W'(NUM_WIN)) begin
      kind     = MAP_WIN;
      sel_bank = win_bank[seg - 1'b1];
      seg1_ram = (seg == SEG_W'(1)) && !rom_in_seg1;
    end
  end

  always_comb begin
    unique case (kind)
      MAP_NONE: rom_addr = '0;
      MAP_WIN:  rom_addr = ROM_AW'({sel_bank, cpu_addr[WIN_AW-1:0]});
      default:  rom_addr = ROM_AW'({lin_bank, cpu_addr});
    endcase
    ram_addr = RAM_AW'({win_bank[0], cpu_addr[WIN_AW-1:0]});
    ram_cs   = cpu_req && (kind == MAP_WIN) && seg1_ram;
    rom_cs   = cpu_req && (kind != MAP_NONE) && !seg1_ram;
  end

  p_one_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_cs && ram_cs));

  p_ram_only_seg1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> ((cpu_addr[CPU_AW-1:WIN_AW] == SEG_W'(1)) && !rom_in_seg1));

  p_seg0_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_addr[CPU_AW-1:WIN_AW] == '0) || !cpu_req) |-> (!rom_cs && !ram_cs));

  p_seg1_rom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && rom_in_seg1 && (cpu_addr[CPU_AW-1:WIN_AW] == SEG_W'(1))) |-> rom_cs);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter  int LIN_W  = 6,
  parameter  int BANK_W = 10,
  parameter  int CPU_AW = 20,
  parameter  int WIN_AW = 16,
  localparam int ROM_AW = ((LIN_W + CPU_AW) > (BANK_W + WIN_AW)) ?
                          (LIN_W + CPU_AW) : (BANK_W + WIN_AW),
  localparam int RAM_AW = BANK_W + WIN_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_we,
  output logic [7:0]        io_rdata,
  input  logic              cpu_req,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              rom_cs,
  output logic              ram_cs
);
  logic                           rst_int_n;
  logic [LIN_W-1:0]               lin_bank;
  logic [NUM_WIN-1:0][BANK_W-1:0] win_bank;
  logic                           rom_in_seg1;

  cbm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  cbm_bank_regs #(.LIN_W(LIN_W), .BANK_W(BANK_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .io_we       (io_we),
    .io_addr     (io_addr),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .lin_bank    (lin_bank),
    .win_bank    (win_bank),
    .rom_in_seg1 (rom_in_seg1)
  );

  cbm_addr_xlate #(
    .LIN_W(LIN_W), .BANK_W(BANK_W), .CPU_AW(CPU_AW), .WIN_AW(WIN_AW),
    .ROM_AW(ROM_AW), .RAM_AW(RAM_AW)
  ) u_xlate (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cpu_req     (cpu_req),
    .cpu_addr    (cpu_addr),
    .lin_bank    (lin_bank),
    .win_bank    (win_bank),
    .rom_in_seg1 (rom_in_seg1),
    .rom_addr    (rom_addr),
    .ram_addr    (ram_addr),
    .rom_cs      (rom_cs),
    .ram_cs      (ram_cs)
  );
endmodule

// File: tb/cart_bank_mapper_tb_top.sv
module cart_bank_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_addr = 8'h00;
  logic [7:0]  io_wdata = 8'h00;
  logic        io_we = 1'b0;
  logic [7:0]  io_rdata;
  logic        cpu_req = 1'b0;
  logic [19:0] cpu_addr = 20'h0;
  logic [25:0] rom_addr;
  logic [25:0] ram_addr;
  logic        rom_cs;
  logic        ram_cs;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;
  bit r1_scan  = 0;

  always #2 clk = ~clk;

  cart_bank_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_we(io_we), .io_rdata(io_rdata), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .rom_cs(rom_cs), .ram_cs(ram_cs)
  );

  // behavioural reference state
  int m_lin;
  int m_win[3];
  int m_ctl;
  int m_edges;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lin = 0; m_ctl = 0; m_edges = 0;
      foreach (m_win[k]) m_win[k] = 0;
    end else begin
      if (m_edges >= 2 && io_we) begin
        int a, d;
        a = io_addr; d = io_wdata;
        if (a == 'hC0 || a == 'hCF) m_lin = d % 64;
        if (a == 'hCE) m_ctl = d % 2;
        for (int k = 0; k < 3; k++) begin
          if (a == 'hC1 + k || a == 'hD0 + 2 * k) m_win[k] = (m_win[k] / 256) * 256 + d;
          if (a == 'hD1 + 2 * k) m_win[k] = (d % 4) * 256 + m_win[k] % 256;
        end
      end
      m_edges++;
    end
  end

  function automatic int exp_rdata(int a);
    if (a == 'hC0 || a == 'hCF) return m_lin;
    if (a == 'hCE) return m_ctl;
    for (int k = 0; k < 3; k++) begin
      if (a == 'hC1 + k || a == 'hD0 + 2 * k) return m_win[k] % 256;
      if (a == 'hD1 + 2 * k) return m_win[k] / 256;
    end
    return 0;
  endfunction

  function automatic string rd_tag(int a);
    if (r1_scan) return "R1";
    if (a == 'hC0 || a == 'hCF) return "R2";
    if (a >= 'hC1 && a <= 'hC3) return "R3";
    if (a >= 'hD0 && a <= 'hD5) return "R4";
    return "R10";
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int seg, lo;
    longint e_rom, e_ram;
    bit e_rcs, e_mcs;
    string t;
    seg = cpu_addr / 65536;
    lo  = cpu_addr % 65536;
    e_ram = longint'(m_win[0]) * 65536 + lo;
    if (seg == 0)      begin e_rom = 0; t = "R9"; end
    else if (seg == 1) begin e_rom = longint'(m_win[0]) * 65536 + lo; t = m_ctl ? "R8" : "R7"; end
    else if (seg <= 3) begin e_rom = longint'(m_win[seg-1]) * 65536 + lo; t = "R6"; end
    else               begin e_rom = longint'(m_lin) * 1048576 + cpu_addr; t = "R5"; end
    e_rcs = cpu_req && (seg >= 2 || (seg == 1 && m_ctl == 1));
    e_mcs = cpu_req && seg == 1 && m_ctl == 0;
    if (!cpu_req) t = {t, "/R9"};
    if (io_we) t = {t, "/R11"};
    if (r1_scan) t = "R1";
    chk(rd_tag(io_addr), "io_rdata", io_rdata, exp_rdata(io_addr));
    chk(t, "rom_addr", rom_addr, e_rom);
    chk(t, "ram_addr", ram_addr, e_ram);
    chk(t, "rom_cs", rom_cs, e_rcs);
    chk(t, "ram_cs", ram_cs, e_mcs);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    io_addr = a; io_wdata = d; io_we = 1'b1;
    cyc();
    io_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    io_addr = a;
    cyc();
  endtask

  task automatic acc(logic [19:0] a, bit req);
    cpu_addr = a; cpu_req = req;
    cyc();
  endtask

  localparam logic [7:0] MAP_PORTS [16] = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hCE, 8'hCF,
    8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hD5, 8'hC4, 8'hCD, 8'hD6, 8'hBF};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state on every port and in translation
    r1_scan = 1;
    for (int i = 0; i < 16; i++) rd(MAP_PORTS[i]);
    acc(20'h5_1234, 1'b1);
    acc(20'h1_0042, 1'b1);
    r1_scan = 0;

    // R2: linear bank through both ports, upper bits zero
    wr(8'hC0, 8'hFF); rd(8'hCF);
    wr(8'hCF, 8'h25); rd(8'hC0);
    // R4 then R3: high byte kept by short write
    wr(8'hD1, 8'hFF); wr(8'hC1, 8'hAA); rd(8'hD1); rd(8'hD0);
    wr(8'hD3, 8'h02); wr(8'hD2, 8'h5C); rd(8'hC2);
    wr(8'hD5, 8'h01); wr(8'hC3, 8'h81); rd(8'hD4); rd(8'hD5);
    // R5, R6, R7, R9 across all segments
    for (int s = 0; s < 16; s++) acc(20'(s * 65536 + 16'hBEEF), 1'b1);
    acc(20'h2_0001, 1'b0);
    // R8 and R10: control bit remaps segment 1
    wr(8'hCE, 8'hFF); rd(8'hCE);
    acc(20'h1_F00D, 1'b1);
    wr(8'hCE, 8'h00); acc(20'h1_F00D, 1'b1);
    // R10: unmapped ports ignore writes and read zero
    wr(8'hC4, 8'h77); wr(8'hD6, 8'h33); rd(8'hCD);
    for (int i = 0; i < 12; i++) rd(MAP_PORTS[i]);
    // R11: write while a linear access is presented
    cpu_addr = 20'hA_0000; cpu_req = 1'b1;
    wr(8'hCF, 8'h3E);

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      io_addr  = MAP_PORTS[$urandom_range(15)];
      io_wdata = 8'($urandom);
      io_we    = ($urandom_range(2) == 0);
      cpu_addr = 20'($urandom);
      cpu_req  = ($urandom_range(3) != 0);
      cyc();
    end
    io_we = 1'b0;
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule